// File: doc/BRIEF.md
# Frame-Difference Scene Change Detector

This block watches a single stream of video pixels and decides, frame by frame, whether the picture has changed enough to count as a new scene. Pixels arrive one per handshake. A start-of-frame marker travels on the first pixel, and an end-of-line marker travels on the last pixel of each row. The block keeps a reference copy of the previous frame's sampled pixels in an internal buffer. It accumulates the sum of absolute differences (SAD) between each incoming frame and that reference, and at the same time replaces the reference with the new pixels.

Configuration inputs set the frame width, frame height, a spatial subsample factor and a SAD threshold. A write is held in shadow storage and takes effect only when the next frame starts. When a frame ends, the block publishes the SAD, pulses a done strobe for one cycle and updates the scene-change flag. The flag is set when the SAD is strictly greater than the threshold.

Top module: `scene_sad_detector`

## Requirements
- R1: After reset, `sad_value` is 0, `sad_done` is 0 and `scene_change` is 0, and `s_tready` is high from the first cycle after reset is released.
- R2: For each pair of consecutive frames, `sad_value` holds the sum of |new − previous| over the sampled positions. `sad_done` is high for exactly one cycle, namely the cycle after the edge that accepts the frame's last pixel.
- R3: The accumulator never wraps. With the default 32×32 frame, going from an all-0 frame to an all-255 frame gives 261120.
- R4: `scene_change` is updated with each report. It is 1 only when the SAD is strictly greater than the threshold; a SAD equal to the threshold gives 0.
- R5: A pixel is sampled only when its row index and its column index are both multiples of the subsample factor (indices start at 0). A factor of 0 behaves as 1. Only sampled pixels enter the SAD and the reference buffer.
- R6: The first frame after reset, and the first frame after a configuration write takes effect, only loads the reference buffer. It gives no `sad_done` pulse and leaves `sad_value` and `scene_change` as they were.
- R7: A configuration write (`cfg_we` high at a clock edge) made during a frame does not change that frame. It takes effect at the next accepted start-of-frame pixel.
- R8: A pixel is taken only at an edge where `s_tvalid` and `s_tready` are both high. Data, start-of-frame and end-of-line values seen in cycles where `s_tvalid` is low have no effect.
- R9: A row ends at the pixel that carries `s_tlast`, or after `width` pixels, whichever comes first. The frame ends with the last pixel of row `height−1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_width | input | CW | Pixels per row (1..MAX_COLS) |
| cfg_height | input | RW | Rows per frame (1..MAX_ROWS) |
| cfg_sub | input | SUB_W | Subsample factor (0 treated as 1) |
| cfg_thresh | input | SAD_W | Scene-change threshold |
| s_tdata | input | PIX_W | Pixel value |
| s_tvalid | input | 1 | Pixel valid |
| s_tready | output | 1 | Block ready for a pixel |
| s_tuser | input | 1 | Start-of-frame marker on the first pixel |
| s_tlast | input | 1 | End-of-line marker on the last pixel of a row |
| sad_value | output | SAD_W | Latched SAD of the last reported frame |
| sad_done | output | 1 | One-cycle strobe when a new SAD is published |
| scene_change | output | 1 | Result of the last threshold comparison |

## Verification
The bench builds the block with its defaults: 8-bit pixels, a 32×32 maximum frame and a 3-bit subsample field. With these values a full-size frame of opposite extremes is short enough to send, so the widest SAD is exercised in a run of a few thousand cycles. The same build runs smaller frames with subsample factors 0, 1, 2 and 3, valid gaps that carry stray markers, and a configuration write in the middle of a frame. A model in the bench holds its own reference copy of each frame and predicts every SAD.

// File: rtl/scene_sad_detector.sv
module scene_sad_detector #(
  parameter  int PIX_W    = 8,
  parameter  int MAX_COLS = 32,
  parameter  int MAX_ROWS = 32,
  parameter  int SUB_W    = 3,
  localparam int CW       = $clog2(MAX_COLS + 1),
  localparam int RW       = $clog2(MAX_ROWS + 1),
  localparam int SAD_W    = PIX_W + $clog2(MAX_COLS * MAX_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_width,
  input  logic [RW-1:0]    cfg_height,
  input  logic [SUB_W-1:0] cfg_sub,
  input  logic [SAD_W-1:0] cfg_thresh,
  input  logic [PIX_W-1:0] s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic             s_tuser,
  input  logic             s_tlast,
  output logic [SAD_W-1:0] sad_value,
  output logic             sad_done,
  output logic             scene_change
);
  localparam int CI    = $clog2(MAX_COLS);
  localparam int RI    = $clog2(MAX_ROWS);
  localparam int DEPTH = MAX_COLS * MAX_ROWS;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = SUB_W + 1;

  logic [CW-1:0]    sh_w, act_w;
  logic [RW-1:0]    sh_h, act_h;
  logic [SUB_W-1:0] sh_sub, act_sub;
  logic [SAD_W-1:0] sh_thr, act_thr;
  logic             pend, primed, in_frame, rdy;
  logic [CI-1:0]    col;
  logic [RI-1:0]    row;
  logic [SUB_W-1:0] cph, rph;
  logic [SAD_W-1:0] acc;
  logic [PIX_W-1:0] ref_mem [DEPTH];

  wire hs   = s_tvalid & s_tready;
  wire sof  = hs & s_tuser;
  wire beat = hs & (in_frame | s_tuser);

  wire [CW-1:0]    eff_w   = s_tuser ? sh_w   : act_w;
  wire [RW-1:0]    eff_h   = s_tuser ? sh_h   : act_h;
  wire [SUB_W-1:0] eff_sub = s_tuser ? sh_sub : act_sub;
  wire [SAD_W-1:0] eff_thr = s_tuser ? sh_thr : act_thr;
  wire             prim_now = s_tuser ? (primed & ~pend) : primed;

  wire [CI-1:0]    cur_col = s_tuser ? '0 : col;
  wire [RI-1:0]    cur_row = s_tuser ? '0 : row;
  wire [SUB_W-1:0] cur_cph = s_tuser ? '0 : cph;
  wire [SUB_W-1:0] cur_rph = s_tuser ? '0 : rph;

  wire wrap_c = (PW'(cur_cph) + PW'(1)) >= PW'(eff_sub);
  wire wrap_r = (PW'(cur_rph) + PW'(1)) >= PW'(eff_sub);
  wire take   = beat && cur_cph == '0 && cur_rph == '0;

  wire line_end  = s_tlast || (CW'(cur_col) + CW'(1) >= eff_w) ||
                   (cur_col == CI'(MAX_COLS - 1));
  wire frame_end = line_end && ((RW'(cur_row) + RW'(1) >= eff_h) ||
                   (cur_row == RI'(MAX_ROWS - 1)));

  wire [AW-1:0]    addr  = AW'(cur_row) * AW'(MAX_COLS) + AW'(cur_col);
  wire [PIX_W-1:0] ref_q = ref_mem[addr];
  wire [PIX_W-1:0] diff  = (s_tdata > ref_q) ? s_tdata - ref_q : ref_q - s_tdata;
  wire [SAD_W-1:0] acc_next = (s_tuser ? '0 : acc) + (take ? SAD_W'(diff) : '0);

  assign s_tready = rdy;

  always_ff @(posedge clk)
    if (take) ref_mem[addr] <= s_tdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_w <= CW'(MAX_COLS);  act_w <= CW'(MAX_COLS);
      sh_h <= RW'(MAX_ROWS);  act_h <= RW'(MAX_ROWS);
      sh_sub <= SUB_W'(1);    act_sub <= SUB_W'(1);
      sh_thr <= '0;           act_thr <= '0;
      pend <= 1'b0; primed <= 1'b0; in_frame <= 1'b0; rdy <= 1'b0;
      col <= '0; row <= '0; cph <= '0; rph <= '0; acc <= '0;
      sad_value <= '0; sad_done <= 1'b0; scene_change <= 1'b0;
    end else begin
      rdy      <= 1'b1;
      sad_done <= 1'b0;
      if (cfg_we) begin
        sh_w <= cfg_width; sh_h <= cfg_height; sh_sub <= cfg_sub; sh_thr <= cfg_thresh;
        pend <= 1'b1;
      end else if (sof) begin
        pend <= 1'b0;
      end
      if (sof) begin
        act_w <= sh_w; act_h <= sh_h; act_sub <= sh_sub; act_thr <= sh_thr;
        if (pend) primed <= 1'b0;
      end
      if (beat) begin
        acc <= acc_next;
        if (frame_end) begin
          in_frame <= 1'b0;
          col <= '0; row <= '0; cph <= '0; rph <= '0;
          primed   <= 1'b1;
          sad_done <= prim_now;
          if (prim_now) begin
            sad_value    <= acc_next;
            scene_change <= acc_next > eff_thr;
          end
        end else begin
          in_frame <= 1'b1;
          if (line_end) begin
            col <= '0; cph <= '0;
            row <= cur_row + RI'(1);
            rph <= wrap_r ? '0 : cur_rph + SUB_W'(1);
          end else begin
            col <= cur_col + CI'(1);
            row <= cur_row;
            rph <= cur_rph;
            cph <= wrap_c ? '0 : cur_cph + SUB_W'(1);
          end
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !s_tuser) |=> acc >= $past(acc)); // R3
  AST_STRICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sad_done |-> (scene_change == (sad_value > act_thr))); // R4
  AST_PRIMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sad_done |-> $past(primed)); // R6
  AST_CFG_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> ($stable(act_w) && $stable(act_h) && $stable(act_sub) && $stable(act_thr))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s_tvalid |=> ($stable(acc) && $stable(row) && $stable(col))); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> !sad_done); // R2
endmodule

// File: tb/scene_sad_detector_tb_top.sv
module scene_sad_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_width = '0;
  logic [5:0]  cfg_height = '0;
  logic [2:0]  cfg_sub = '0;
  logic [17:0] cfg_thresh = '0;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
  logic        s_tready, sad_done, scene_change;
  logic [17:0] sad_value;

  int total = 0, bad = 0;
  int m_w = 32, m_h = 32, m_sub = 1, m_thr = 0;
  int n_w = 32, n_h = 32, n_sub = 1, n_thr = 0;
  bit m_pend = 0, m_primed = 0;
  int refm [32][32];
  int last_sad = 0;
  bit last_scene = 0;

  always #5 clk = ~clk;

  scene_sad_detector dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_sub(cfg_sub), .cfg_thresh(cfg_thresh),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tuser(s_tuser), .s_tlast(s_tlast), .sad_value(sad_value),
    .sad_done(sad_done), .scene_change(scene_change)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pv(input int seed, input int r, input int c);
    if (seed == 0) return 0;
    if (seed == 1000) return 255;
    return (seed * 53 + r * 29 + c * 17 + r * c * 7) % 256;
  endfunction

  function automatic bit sampled(input int r, input int c, input int sub);
    int s = (sub == 0) ? 1 : sub;
    return (r % s == 0) && (c % s == 0);
  endfunction

  function automatic int pair_sad(input int a, input int b, input int w, input int h, input int sub);
    int s = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        if (sampled(r, c, sub)) begin
          int d = pv(b, r, c) - pv(a, r, c);
          s += (d < 0) ? -d : d;
        end
    return s;
  endfunction

  task automatic stage_cfg(input int w, input int h, input int sub, input int thr);
    cfg_width = 6'(w); cfg_height = 6'(h); cfg_sub = 3'(sub); cfg_thresh = 18'(thr);
    n_w = w; n_h = h; n_sub = sub; n_thr = thr;
  endtask

  task automatic cfg_write(input int w, input int h, input int sub, input int thr);
    @(negedge clk);
    stage_cfg(w, h, sub, thr);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_pend = 1;
  endtask

  task automatic send_frame(input int seed, input bit gap, input int mid_beat,
                            input string req, output int exp);
    bit rep;
    int idx = 0;
    if (m_pend) begin
      m_w = n_w; m_h = n_h; m_sub = n_sub; m_thr = n_thr;
      m_pend = 0; m_primed = 0;
    end
    rep = m_primed;
    exp = 0;
    for (int r = 0; r < m_h; r++)
      for (int c = 0; c < m_w; c++)
        if (sampled(r, c, m_sub)) begin
          int d = pv(seed, r, c) - refm[r][c];
          exp += (d < 0) ? -d : d;
          refm[r][c] = pv(seed, r, c);
        end
    for (int r = 0; r < m_h; r++)
      for (int c = 0; c < m_w; c++) begin
        if (gap && idx % 2 == 1) begin
          @(negedge clk);
          s_tvalid = 1'b0; s_tdata = 8'hA5; s_tuser = 1'b1; s_tlast = 1'b1; cfg_we = 1'b0;
        end
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = 8'(pv(seed, r, c));
        s_tuser  = (r == 0 && c == 0);
        s_tlast  = (c == m_w - 1);
        cfg_we   = (idx == mid_beat);
        if (idx == mid_beat) m_pend = 1;
        idx++;
      end
    @(negedge clk);
    s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0; cfg_we = 1'b0;
    if (rep) begin
      check(sad_done == 1'b1, {req, " done pulse (R2)"}, int'(sad_done), 1);
      check(int'(sad_value) == exp, {req, " sad value (R2)"}, int'(sad_value), exp);
      check(scene_change == (exp > m_thr), {req, " scene flag (R4)"}, int'(scene_change), int'(exp > m_thr));
      last_sad = exp; last_scene = (exp > m_thr);
    end else begin
      check(sad_done == 1'b0, {req, " no report on priming frame (R6)"}, int'(sad_done), 0);
      check(int'(sad_value) == last_sad, {req, " sad kept while priming (R6)"}, int'(sad_value), last_sad);
    end
    @(negedge clk);
    check(sad_done == 1'b0, {req, " done lasts one cycle (R2)"}, int'(sad_done), 0);
    m_primed = 1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(int'(sad_value) == 0, "R1 sad after reset", int'(sad_value), 0);
    check(sad_done == 1'b0, "R1 done after reset", int'(sad_done), 0);
    check(scene_change == 1'b0, "R1 flag after reset", int'(scene_change), 0);
    check(s_tready == 1'b1, "R1 ready", int'(s_tready), 1);
  endtask

  task automatic t_basic;
    int e;
    cfg_write(8, 6, 1, 100);
    send_frame(1, 0, -1, "R6 first frame", e);
    send_frame(2, 0, -1, "R2 R9 second frame", e);
    send_frame(2, 0, -1, "R2 repeat frame", e);
    check(e == 0, "R2 identical frames give zero", e, 0);
  endtask

  task automatic t_thresh;
    int e, t;
    t = pair_sad(3, 4, 8, 6, 1);
    cfg_write(8, 6, 1, t);
    send_frame(3, 0, -1, "R4 prime", e);
    send_frame(4, 0, -1, "R4 equal threshold", e);
    check(scene_change == 1'b0, "R4 equal gives no change", int'(scene_change), 0);
    cfg_write(8, 6, 1, t - 1);
    send_frame(3, 0, -1, "R4 prime again", e);
    send_frame(4, 0, -1, "R4 one below", e);
    check(scene_change == 1'b1, "R4 above threshold", int'(scene_change), 1);
  endtask

  task automatic t_sub;
    int e;
    cfg_write(12, 9, 3, 0);
    send_frame(5, 0, -1, "R5 sub3 prime", e);
    send_frame(6, 0, -1, "R5 sub3", e);
    cfg_write(10, 10, 2, 500);
    send_frame(7, 0, -1, "R5 sub2 prime", e);
    send_frame(8, 0, -1, "R5 sub2", e);
    cfg_write(6, 4, 0, 0);
    send_frame(9, 0, -1, "R5 sub0 prime", e);
    send_frame(10, 0, -1, "R5 sub0 as one", e);
    check(e == pair_sad(9, 10, 6, 4, 1), "R5 factor zero equals one", e, pair_sad(9, 10, 6, 4, 1));
  endtask

  task automatic t_gap;
    int e;
    send_frame(11, 1, -1, "R8 gaps", e);
    send_frame(12, 1, -1, "R8 gaps again", e);
  endtask

  task automatic t_mid;
    int e;
    cfg_write(8, 8, 1, 50);
    send_frame(13, 0, -1, "R7 prime", e);
    stage_cfg(16, 4, 2, 10);
    send_frame(14, 0, 10, "R7 write mid-frame", e);
    send_frame(15, 0, -1, "R7 new config primes", e);
    send_frame(16, 0, -1, "R7 new config in use", e);
  endtask

  task automatic t_max;
    int e;
    cfg_write(32, 32, 1, 0);
    send_frame(0, 0, -1, "R3 prime zeros", e);
    send_frame(1000, 0, -1, "R3 full swing", e);
    check(int'(sad_value) == 261120, "R3 widest sum", int'(sad_value), 261120);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_thresh();
    t_sub();
    t_gap();
    t_mid();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule